// File: doc/BRIEF.md
# I2C-controlled one-of-four channel selector with interrupt gathering

The block is an I2C bus slave that decides which one of four downstream channels is connected, and that gathers four active-low interrupt lines into one shared active-low interrupt output. The system clock oversamples SCL and SDA. The block pulls SDA low through an open-drain enable and never drives it high. The 7-bit slave address has a fixed upper nibble, set by a parameter, and a lower three bits taken from strap pins.

A master writes one control byte to choose a channel. The choice reaches the channel-enable outputs only when the next STOP appears on the bus. This means the downstream connection never changes in the middle of a transfer. When the master reads the register, it gets the live interrupt state in the upper nibble and the stored selection in the lower bits. This lets the master find which channel is raising an interrupt. The analog switches and the electrical levels are outside this block.

Top module: `i2c_chan_sel`

## Requirements
- R1: After a START, the block acknowledges (drives SDA low in the ninth clock) an address byte whose upper seven bits equal {ADDR_HI, strap_i}. The eighth bit selects the direction: 1 is read and 0 is write.
- R2: An address that does not match gets no acknowledge. The block then ignores all following bytes until the next START or STOP, and the control register stays unchanged.
- R3: In a write, every data byte after the address is acknowledged and stored. When several bytes arrive, the last one is kept.
- R4: When control bit 2 is 0, no channel is enabled. When bit 2 is 1, exactly chan_en_o[bits 1:0] is set. At most one enable is ever high.
- R5: A newly written selection does not change chan_en_o until a STOP is seen on the bus.
- R6: A read returns the byte {active(ch3), active(ch2), active(ch1), active(ch0), 0, ctrl[2:0]}, most significant bit first. A bit in the upper nibble is 1 when that channel's irq_n_i is low at the moment the byte starts. A master ACK makes the block send the byte again; a master NACK ends the transfer.
- R7: irq_n_o is low whenever any irq_n_i is low, whether or not that channel is selected. It returns high only once all four inputs are high, and it holds no latched state.
- R8: After reset, the control register is zero and no channel is enabled.
- R9: Bit 3 of a written byte is ignored, and it always reads back as 0.
- R10: A repeated START, in any state, restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as sensed |
| sda_i | input | 1 | Bus data line as sensed |
| strap_i | input | 3 | Low three address bits |
| irq_n_i | input | 4 | Active-low interrupt from each channel (bit n = channel n) |
| sda_oe_o | output | 1 | When 1, SDA is pulled low |
| chan_en_o | output | 4 | One-hot channel enables |
| irq_n_o | output | 1 | Active-low combined interrupt |

## Verification
On every cycle, the assertions check four things: the channel enables stay one-hot or zero, they change only in the cycle after a detected STOP, the control register changes only while a write byte is being received, and the SDA drive changes only while the synchronized SCL is low. The bench scenarios are needed for everything the bus conversation decides. That covers address matching and NACK with the following bytes ignored, keeping only the last of several write bytes, the exact read-back format with live interrupts, repeated reads on master ACK, masking of bit 3, and a repeated START in the middle of a transfer.

// File: rtl/i2c_chan_sel.sv
module i2c_chan_sel #(
  parameter logic [3:0] ADDR_HI = 4'b1110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic [3:0] irq_n_i,
  output logic       sda_oe_o,
  output logic [3:0] chan_en_o,
  output logic       irq_n_o
);
  localparam int NCH = 4;
  localparam int SELW = $clog2(NCH);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDATA, S_WACK, S_RDATA, S_RACK, S_IGN
  } st_t;

  logic [2:0] scl_sh, sda_sh;
  logic       scl_s, scl_q, sda_s, sda_q;
  logic       start_det, stop_det, scl_rise, scl_fall;

  st_t        st;
  logic [2:0] cnt;
  logic [7:0] shr, txb;
  logic       byte_done, rw, mack, oe;
  logic [2:0] ctrl_q;
  logic [NCH-1:0] chan_en_q;
  logic [7:0] rdval;
  logic [NCH-1:0] sel_dec;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sh <= 3'b111;
      sda_sh <= 3'b111;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_i};
      sda_sh <= {sda_sh[1:0], sda_i};
    end

  assign scl_s = scl_sh[1];
  assign scl_q = scl_sh[2];
  assign sda_s = sda_sh[1];
  assign sda_q = sda_sh[2];
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;

  assign rdval   = {~irq_n_i, 1'b0, ctrl_q};
  assign sel_dec = ctrl_q[2] ? (NCH'(1) << ctrl_q[SELW-1:0]) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      shr <= '0;
      txb <= '0;
      byte_done <= 1'b0;
      rw <= 1'b0;
      mack <= 1'b0;
      oe <= 1'b0;
      ctrl_q <= '0;
      chan_en_q <= '0;
    end else if (start_det) begin
      st <= S_ADDR;
      cnt <= '0;
      byte_done <= 1'b0;
      oe <= 1'b0;
    end else if (stop_det) begin
      st <= S_IDLE;
      oe <= 1'b0;
      byte_done <= 1'b0;
      chan_en_q <= sel_dec;
    end else begin
      case (st)
        S_ADDR, S_WDATA: begin
          if (scl_rise) begin
            shr <= {shr[6:0], sda_s};
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              byte_done <= 1'b1;
              if (st == S_WDATA) ctrl_q <= {shr[1:0], sda_s};
            end
          end else if (scl_fall && byte_done) begin
            byte_done <= 1'b0;
            if (st == S_WDATA) begin
              oe <= 1'b1;
              st <= S_WACK;
            end else if (shr[7:1] == {ADDR_HI, strap_i}) begin
              rw <= shr[0];
              oe <= 1'b1;
              st <= S_AACK;
            end else begin
              st <= S_IGN;
            end
          end
        end
        S_AACK: if (scl_fall) begin
          cnt <= '0;
          if (rw) begin
            st <= S_RDATA;
            txb <= rdval;
            oe <= ~rdval[7];
          end else begin
            st <= S_WDATA;
            oe <= 1'b0;
          end
        end
        S_WACK: if (scl_fall) begin
          oe <= 1'b0;
          cnt <= '0;
          st <= S_WDATA;
        end
        S_RDATA: if (scl_fall) begin
          if (cnt == 3'd7) begin
            oe <= 1'b0;
            cnt <= '0;
            st <= S_RACK;
          end else begin
            txb <= {txb[6:0], 1'b0};
            oe <= ~txb[6];
            cnt <= cnt + 3'd1;
          end
        end
        S_RACK: begin
          if (scl_rise) mack <= ~sda_s;
          else if (scl_fall) begin
            if (mack) begin
              st <= S_RDATA;
              txb <= rdval;
              oe <= ~rdval[7];
            end else begin
              st <= S_IGN;
            end
          end
        end
        default: ;
      endcase
    end

  assign sda_oe_o  = oe;
  assign chan_en_o = chan_en_q;
  assign irq_n_o   = &irq_n_i;

  p_en_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_en_o));

  p_en_at_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_en_o) |-> $past(stop_det));

  p_ctrl_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> $past(st == S_WDATA));

  p_oe_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> $past(!scl_s));
endmodule

// File: tb/i2c_chan_sel_bench.sv
module i2c_chan_sel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;
  localparam logic [6:0] DEV = {4'b1110, 3'b101};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic [3:0] irq_n = 4'hF;
  logic sda_oe, int_n;
  logic [3:0] chan_en;
  logic sda_line;
  int checks = 0, fails = 0;
  bit done = 0;

  assign sda_line = sda_m & ~sda_oe;

  i2c_chan_sel u_i2c_chan_sel (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_i(strap), .irq_n_i(irq_n), .sda_oe_o(sda_oe),
    .chan_en_o(chan_en), .irq_n_o(int_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bstart();
    sda_m = 1'b1; waitc(H); scl = 1'b1; waitc(H);
    sda_m = 1'b0; waitc(H); scl = 1'b0; waitc(H/2);
  endtask

  task automatic bstop();
    sda_m = 1'b0; waitc(H); scl = 1'b1; waitc(H);
    sda_m = 1'b1; waitc(H);
  endtask

  task automatic wbit(input logic b);
    sda_m = b; waitc(H); scl = 1'b1; waitc(H); scl = 1'b0; waitc(H/2);
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; waitc(H); scl = 1'b1; waitc(H/2);
    b = sda_line; waitc(H/2); scl = 1'b0; waitc(H/2);
  endtask

  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rbyte(input logic ack_m, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) rbit(v[i]);
    wbit(~ack_m);
  endtask

  task automatic wr(input logic [7:0] v);
    logic a;
    bstart(); wbyte({DEV, 1'b0}, a); wbyte(v, a); bstop();
  endtask

  task automatic rd(output logic [7:0] v);
    logic a;
    bstart(); wbyte({DEV, 1'b1}, a); rbyte(1'b0, v); bstop();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk(chan_en == 4'h0, "R8 enables after reset", chan_en, 0);
    chk(int_n == 1'b1, "R7 idle irq out", int_n, 1);
    rd(v);
    chk(v == 8'h00, "R8 register after reset", v, 0);
  endtask

  task automatic t_addr();
    logic a;
    logic [7:0] v;
    bstart(); wbyte({DEV, 1'b0}, a); bstop();
    chk(a, "R1 write address ack", a, 1);
    bstart(); wbyte({DEV, 1'b1}, a); rbyte(1'b0, v); bstop();
    chk(a, "R1 read address ack", a, 1);
  endtask

  task automatic t_nack();
    logic a;
    logic [7:0] v;
    bstart(); wbyte({7'h74, 1'b0}, a);
    chk(!a, "R2 wrong address nack", a, 0);
    wbyte(8'h05, a);
    chk(!a, "R2 data after nack", a, 0);
    bstop();
    rd(v);
    chk(v == 8'h00, "R2 register untouched", v, 0);
    chk(chan_en == 4'h0, "R2 enables untouched", chan_en, 0);
  endtask

  task automatic t_decode();
    for (int k = 4; k < 8; k++) begin
      wr(8'(k));
      chk(chan_en == (4'b1 << (k - 4)), "R4 channel decode", chan_en, 1 << (k - 4));
    end
    wr(8'h03);
    chk(chan_en == 4'h0, "R4 bit2 clear selects none", chan_en, 0);
  endtask

  task automatic t_stop();
    logic a;
    bstart(); wbyte({DEV, 1'b0}, a); wbyte(8'h06, a);
    waitc(2 * H);
    chk(chan_en == 4'h0, "R5 no change before stop", chan_en, 0);
    bstop();
    chk(chan_en == 4'b0100, "R5 change at stop", chan_en, 4'b0100);
  endtask

  task automatic t_last();
    logic a;
    logic [7:0] v;
    bstart(); wbyte({DEV, 1'b0}, a);
    wbyte(8'h04, a); wbyte(8'h05, a); wbyte(8'h07, a);
    chk(a, "R3 every byte acked", a, 1);
    bstop();
    chk(chan_en == 4'b1000, "R3 last byte enables", chan_en, 4'b1000);
    rd(v);
    chk(v == 8'h07, "R3 last byte stored", v, 8'h07);
  endtask

  task automatic t_bit3();
    logic [7:0] v;
    wr(8'h0D);
    rd(v);
    chk(v == 8'h05, "R9 bit3 reads zero", v, 8'h05);
    chk(chan_en == 4'b0010, "R9 bit3 no effect", chan_en, 4'b0010);
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] v1, v2;
    irq_n = 4'b1001;
    bstart(); wbyte({DEV, 1'b1}, a);
    rbyte(1'b1, v1); rbyte(1'b0, v2); bstop();
    chk(v1 == 8'h65, "R6 read format", v1, 8'h65);
    chk(v2 == 8'h65, "R6 repeat on ack", v2, 8'h65);
    chk(chan_en == 4'b0010, "R6 read keeps selection", chan_en, 4'b0010);
    irq_n = 4'hF;
  endtask

  task automatic t_int();
    wr(8'h04);
    irq_n = 4'b0111; #1;
    chk(int_n == 1'b0, "R7 unselected channel irq", int_n, 0);
    irq_n = 4'b0011; #1;
    chk(int_n == 1'b0, "R7 two sources", int_n, 0);
    irq_n = 4'b1011; #1;
    chk(int_n == 1'b0, "R7 one source remains", int_n, 0);
    irq_n = 4'b1111; #1;
    chk(int_n == 1'b1, "R7 all cleared", int_n, 1);
  endtask

  task automatic t_rstart();
    logic a;
    logic [7:0] v;
    bstart(); wbyte({DEV, 1'b0}, a); wbyte(8'h06, a);
    bstart(); wbyte({DEV, 1'b1}, a);
    chk(a, "R10 ack after repeated start", a, 1);
    rbyte(1'b0, v); bstop();
    chk(v == 8'h06, "R10 read after repeated start", v, 8'h06);
    chk(chan_en == 4'b0100, "R10 selection at stop", chan_en, 4'b0100);
    bstart(); wbyte({7'h70, 1'b0}, a);
    bstart(); wbyte({DEV, 1'b0}, a);
    chk(a, "R10 restart after nack", a, 1);
    bstop();
  endtask

  initial begin
    waitc(5);
    rst_n = 1'b1;
    waitc(5);
    t_reset();
    t_addr();
    t_nack();
    t_decode();
    t_stop();
    t_last();
    t_bit3();
    t_read();
    t_int();
    t_rstart();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule